// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and turns each one into an interrupt request for the processor core. Every pin has its own two-bit sense setting. The setting picks low level, any edge, falling edge or rising edge. A small register port lets software write and read the sense settings and a per-pin enable mask. Software can also read the per-pin edge flags and clear any of them by writing a one to its bit. A request reaches the core only when the pin's condition holds, its mask bit is set and the global interrupt enable input is high.

Pins are sampled from the pad, so a pin that the chip drives as an output can still raise an interrupt. This gives software a way to trigger one. The pins fall into two classes. Pins 0 to 3 keep detecting edges while the I/O clock is stopped. Pins 4 to 7 need the `ioclk_run` qualifier to be high for their edge history to move. Level detection works on all pins at all times. While `ioclk_run` is low, the `wake` output rises if a masked pin has a condition that can be seen without the I/O clock.

Inside, each pin has a two-flop synchronizer and a small per-pin unit with two state machines. The history machine has the states HIST_LO and HIST_HI. It moves HIST_LO to HIST_HI when the synchronized pin is seen high, and HIST_HI to HIST_LO when it is seen low, but only when the pin's history is allowed to update. The flag machine has the states FLG_IDLE and FLG_PEND. It moves FLG_IDLE to FLG_PEND when an edge matches the pin's sense setting. It moves FLG_PEND to FLG_IDLE on a write-one clear, unless an edge arrives in the same cycle.

Top module: `eic_ctrl`

## Requirements
- R1: Reset clears the sense register, the mask register and all flags. With these values `irq_req` and `wake` are zero.
- R2: Sense code 00 is low level. While the synchronized pin is low, the pin's request is asserted, and it drops when the pin is high. No flag is ever set in this mode. The request is visible after the second rising clock edge that follows the pin change.
- R3: Sense code 10 is falling edge. A high-to-low transition sets the pin's flag, and a low-to-high transition does not.
- R4: Sense code 11 is rising edge. A low-to-high transition sets the pin's flag, and a high-to-low transition does not.
- R5: Sense code 01 is any edge. A transition in either direction sets the pin's flag.
- R6: In the edge modes, `irq_req[i]` equals `gie & mask[i] & flag[i]`. Clearing `gie` or the mask bit removes the request and leaves the flag set.
- R7: A write to address 2 clears every flag whose data bit is one. Data bits that are zero leave their flags unchanged.
- R8: While `ioclk_run` is low, pins 4 to 7 set no flags. A pulse that starts and ends inside a stopped interval leaves no flag. A level change that persists is flagged after `ioclk_run` returns high. Pins 0 to 3 keep setting flags while `ioclk_run` is low.
- R9: `wake` is high only while `ioclk_run` is low. It is then high when some masked pin is either in level mode with its pin low, or is one of pins 0 to 3 with its flag set.
- R10: The register map is as follows. Address 0 holds the sense setting, with pin i in bits 2i+1:2i. Address 1 holds the mask in bits 7:0. Address 2 holds the flags in bits 7:0. Address 3 reads as zero, and unused read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ioclk_run | input | 1 | High while the I/O clock runs; gates edge history of pins 4 to 7 |
| gie | input | 1 | Global interrupt enable |
| pin_in | input | 8 | Pad values of the eight interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq_req | output | 8 | Per-pin interrupt requests |
| wake | output | 1 | Wake indication while the I/O clock is stopped |

## Verification
The bench targets level mode. A design that latched level hits would leave a flag behind, or keep requesting after the pin goes high. For the two single-edge modes it drives the opposite transition; a design that mixed them up would flag the wrong direction. It drives short pulses on an upper pin while `ioclk_run` is low. A design whose history ran freely would either miss a persisting change or flag a pulse it should not see. It also checks that `wake` stays silent for upper-pin edges, and that a partial write-one clear leaves the other flags intact.

// File: rtl/eic_pkg.sv
package eic_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic {
        HIST_LO = 1'b0,
        HIST_HI = 1'b1
    } hist_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_e;

    localparam logic [1:0] ADDR_SENSE = 2'd0;
    localparam logic [1:0] ADDR_MASK  = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign q_out = stage2_q;

endmodule

// File: rtl/eic_line.sv
module eic_line
    import eic_pkg::*;
#(
    parameter bit NEEDS_IOCLK = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp,
    input  logic       ioclk_run,
    input  logic [1:0] sense,
    input  logic       clr,
    output logic       flag,
    output logic       cond,
    output logic       async_hit
);

    hist_e  hist_q, hist_d;
    flag_e  flag_q, flag_d;
    sense_e mode;
    logic   hist_en;
    logic   rise_seen;
    logic   fall_seen;
    logic   edge_hit;

    assign mode    = sense_e'(sense);
    assign hist_en = NEEDS_IOCLK ? ioclk_run : 1'b1;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= HIST_LO;
            flag_q <= FLG_IDLE;
        end else begin
            hist_q <= hist_d;
            flag_q <= flag_d;
        end
    end

    // edge qualification against the stored history
    always_comb begin
        rise_seen = hist_en && (hist_q == HIST_LO) && samp;
        fall_seen = hist_en && (hist_q == HIST_HI) && !samp;
        unique case (mode)
            SENSE_LOW:  edge_hit = 1'b0;
            SENSE_ANY:  edge_hit = rise_seen || fall_seen;
            SENSE_FALL: edge_hit = fall_seen;
            SENSE_RISE: edge_hit = rise_seen;
            default:    edge_hit = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        hist_d = hist_q;
        unique case (hist_q)
            HIST_LO: if (hist_en && samp)  hist_d = HIST_HI;
            HIST_HI: if (hist_en && !samp) hist_d = HIST_LO;
            default: hist_d = HIST_LO;
        endcase

        flag_d = flag_q;
        unique case (flag_q)
            FLG_IDLE: if (edge_hit)         flag_d = FLG_PEND;
            FLG_PEND: if (clr && !edge_hit) flag_d = FLG_IDLE;
            default:  flag_d = FLG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        flag      = (flag_q == FLG_PEND);
        cond      = (mode == SENSE_LOW) ? !samp : flag;
        async_hit = ((mode == SENSE_LOW) && !samp) || (!NEEDS_IOCLK && flag);
    end

endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
    import eic_pkg::*;
#(
    parameter int N_LINES     = 8,
    parameter int ASYNC_LINES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ioclk_run,
    input  logic                   gie,
    input  logic [N_LINES-1:0]     pin_in,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [2*N_LINES-1:0]   wr_data,
    input  logic [1:0]             rd_addr,
    output logic [2*N_LINES-1:0]   rd_data,
    output logic [N_LINES-1:0]     irq_req,
    output logic                   wake
);

    localparam int DW = 2 * N_LINES;

    logic [DW-1:0]      sense_q;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] flag_q;
    logic [N_LINES-1:0] samp;
    logic [N_LINES-1:0] cond;
    logic [N_LINES-1:0] async_hit;
    logic [N_LINES-1:0] clr_vec;

    eic_sync #(.WIDTH(N_LINES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (samp)
    );

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_SENSE) sense_q <= wr_data;
            if (wr_addr == ADDR_MASK)  mask_q  <= wr_data[N_LINES-1:0];
        end
    end

    assign clr_vec = (wr_en && (wr_addr == ADDR_FLAG)) ? wr_data[N_LINES-1:0] : '0;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        eic_line #(.NEEDS_IOCLK(i >= ASYNC_LINES)) line_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .samp      (samp[i]),
            .ioclk_run (ioclk_run),
            .sense     (sense_q[2*i +: 2]),
            .clr       (clr_vec[i]),
            .flag      (flag_q[i]),
            .cond      (cond[i]),
            .async_hit (async_hit[i])
        );
    end

    // read mux
    always_comb begin
        unique case (rd_addr)
            ADDR_SENSE: rd_data = sense_q;
            ADDR_MASK:  rd_data = {{(DW-N_LINES){1'b0}}, mask_q};
            ADDR_FLAG:  rd_data = {{(DW-N_LINES){1'b0}}, flag_q};
            default:    rd_data = '0;
        endcase
    end

    assign irq_req = gie ? (cond & mask_q) : '0;
    assign wake    = !ioclk_run && |(async_hit & mask_q);

endmodule

// File: rtl/eic_ctrl_chk.sv
module eic_ctrl_chk #(
    parameter int N_LINES     = 8,
    parameter int ASYNC_LINES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ioclk_run,
    input logic                 gie,
    input logic [2*N_LINES-1:0] sense_q,
    input logic [N_LINES-1:0]   mask_q,
    input logic [N_LINES-1:0]   flag_q,
    input logic [N_LINES-1:0]   irq_req,
    input logic                 wake
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sense_q == '0 && mask_q == '0 && flag_q == '0));

    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~mask_q) == '0) && (gie || irq_req == '0));

    a_r8_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ioclk_run |=> ((flag_q[N_LINES-1:ASYNC_LINES]
                         & ~$past(flag_q[N_LINES-1:ASYNC_LINES])) == '0));

    a_r9_wake_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> !ioclk_run);

    for (genvar i = 0; i < N_LINES; i++) begin : g_lvl
        a_r2_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_q[2*i +: 2] == 2'b00) |=> !$rose(flag_q[i]));
    end

endmodule

bind eic_ctrl eic_ctrl_chk #(.N_LINES(N_LINES), .ASYNC_LINES(ASYNC_LINES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ioclk_run (ioclk_run),
    .gie       (gie),
    .sense_q   (sense_q),
    .mask_q    (mask_q),
    .flag_q    (flag_q),
    .irq_req   (irq_req),
    .wake      (wake)
);

// File: tb/eic_ctrl_tb.sv
module eic_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ioclk_run = 1'b1;
    logic        gie = 1'b0;
    logic [7:0]  pin_in = 8'hFF;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic [7:0]  irq_req;
    logic        wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    eic_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ioclk_run (ioclk_run),
        .gie       (gie),
        .pin_in    (pin_in),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq_req   (irq_req),
        .wake      (wake)
    );

    // vector: [15:13] line, [12:11] sense, [10] pin before, [9] pin after,
    //         [8] expected flag, [7] expected request
    localparam logic [15:0] VEC [8] = '{
        {3'd0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 7'd0},
        {3'd1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0},
        {3'd2, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 7'd0},
        {3'd3, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0},
        {3'd4, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 7'd0},
        {3'd5, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 7'd0},
        {3'd6, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 7'd0},
        {3'd7, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    initial begin : watchdog
        #(4 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        tick(3);
        // R1 / R10: reset state
        rd(2'd0, v); check("R1 sense after reset", v, 16'h0);
        rd(2'd1, v); check("R1 mask after reset", v, 16'h0);
        rd(2'd2, v); check("R1 flags after reset", v, 16'h0);
        check("R1 irq after reset", {8'h0, irq_req}, 16'h0);
        check("R1 wake after reset", {15'h0, wake}, 16'h0);
        rst_n = 1'b1;
        tick(4);
        gie = 1'b1;

        // table walk: R2 R3 R4 R5
        for (int k = 0; k < 8; k++) begin
            logic [2:0] ln;
            logic [1:0] md;
            ln = VEC[k][15:13];
            md = VEC[k][12:11];
            wr(2'd0, 16'(md) << (2 * ln));
            wr(2'd1, 16'(1) << ln);
            pin_in[ln] = VEC[k][10];
            tick(6);
            wr(2'd2, 16'h00FF);
            tick(2);
            pin_in[ln] = VEC[k][9];
            tick(6);
            rd(2'd2, v);
            check($sformatf("R2-5 vec %0d flag", k), {15'h0, v[ln]}, {15'h0, VEC[k][8]});
            check($sformatf("R2-5 vec %0d irq", k), {15'h0, irq_req[ln]}, {15'h0, VEC[k][7]});
            pin_in = 8'hFF;
            tick(6);
            wr(2'd2, 16'h00FF);
        end

        // R2 latency: level request after the second edge
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0001);
        tick(2);
        pin_in[0] = 1'b0;
        tick(1);
        check("R2 level irq after one edge", {15'h0, irq_req[0]}, 16'h0);
        tick(1);
        check("R2 level irq after two edges", {15'h0, irq_req[0]}, 16'h1);
        pin_in[0] = 1'b1;
        tick(3);
        check("R2 level irq drops", {15'h0, irq_req[0]}, 16'h0);
        rd(2'd2, v); check("R2 level sets no flag", v, 16'h0);

        // R6: gating by gie and mask
        wr(2'd0, 16'h000A);            // pins 0 and 1 falling
        gie = 1'b0;
        pin_in[0] = 1'b0;
        tick(5);
        check("R6 irq blocked by gie", {8'h0, irq_req}, 16'h0);
        rd(2'd2, v); check("R6 flag set while gie low", v, 16'h0001);
        gie = 1'b1;
        tick(1);
        check("R6 irq with gie", {8'h0, irq_req}, 16'h0001);
        wr(2'd1, 16'h0000);
        check("R6 irq blocked by mask", {8'h0, irq_req}, 16'h0);
        pin_in[1] = 1'b0;
        tick(5);

        // R7: write-one clear
        wr(2'd2, 16'h0000);
        rd(2'd2, v); check("R7 zero write keeps flags", v, 16'h0003);
        wr(2'd2, 16'h0002);
        rd(2'd2, v); check("R7 clears only bit 1", v, 16'h0001);
        wr(2'd2, 16'h00FF);
        rd(2'd2, v); check("R7 clear all", v, 16'h0);
        pin_in = 8'hFF;
        tick(5);
        wr(2'd2, 16'h00FF);

        // R8 / R9: stopped I/O clock
        wr(2'd0, 16'h0A0A);            // pins 0,1,4,5 falling
        wr(2'd1, 16'h0032);            // mask pins 1,4,5
        ioclk_run = 1'b0;
        tick(2);
        pin_in[5] = 1'b0;
        tick(5);
        pin_in[5] = 1'b1;
        tick(5);
        check("R9 no wake for upper pulse", {15'h0, wake}, 16'h0);
        pin_in[4] = 1'b0;
        tick(5);
        rd(2'd2, v); check("R8 upper pins frozen", v, 16'h0);
        check("R9 no wake for upper level change", {15'h0, wake}, 16'h0);
        pin_in[1] = 1'b0;
        tick(5);
        rd(2'd2, v); check("R8 lower pin flags while stopped", v, 16'h0002);
        check("R9 wake on lower flag", {15'h0, wake}, 16'h1);
        ioclk_run = 1'b1;
        tick(4);
        check("R9 wake low with clock", {15'h0, wake}, 16'h0);
        rd(2'd2, v); check("R8 persisting change flagged, pulse not", v, 16'h0012);
        pin_in = 8'hFF;
        tick(5);
        wr(2'd2, 16'h00FF);

        // R9: level wake on an upper pin
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0040);
        ioclk_run = 1'b0;
        pin_in[6] = 1'b0;
        tick(4);
        check("R9 level wake upper pin", {15'h0, wake}, 16'h1);
        pin_in[6] = 1'b1;
        tick(4);
        check("R9 wake drops with level", {15'h0, wake}, 16'h0);
        ioclk_run = 1'b1;

        // R10: register map
        wr(2'd0, 16'hE4B1);
        rd(2'd0, v); check("R10 sense readback", v, 16'hE4B1);
        wr(2'd1, 16'hFFA5);
        rd(2'd1, v); check("R10 mask readback", v, 16'h00A5);
        rd(2'd3, v); check("R10 address 3 reads zero", v, 16'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule